// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block generates the system reset from already-digitised supervision signals. It takes two health flags from external voltage comparators (a supply-good flag and an auxiliary monitor-good flag), a raw active-low push-button or controller reset line, and a one-cycle expiry pulse from a watchdog. From these it drives an active-high reset and its active-low complement. The analog side (thresholds, hysteresis, capacitor-set delays and pad drive) lives elsewhere.

Reset is asserted while the block's own synchronous power-on reset is applied, and whenever any supervision condition is present. Release is governed by a single shared hold counter. The counter starts only when every condition is clean and restarts from zero if any condition comes back. All delays are clock-cycle counts, derived from a reference tick length multiplied by tick counts. Every asynchronous input passes through a two-flop synchroniser. The manual input must stay low for a minimum number of consecutive cycles before it counts as a request. Each accepted request raises a one-cycle strobe, which the watchdog can use to clear itself.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1. After `rst_n` rises with all inputs healthy, `sys_rst_o` stays 1 until the HOLD_CYC+2-th rising clock edge and is 0 after that edge (HOLD_CYC = HOLD_TICKS*TICK_CYC).
- R2: When `supply_ok_i` goes to 0, `sys_rst_o` becomes 1 after exactly the third rising edge that samples the low level.
- R3: When `monitor_ok_i` goes to 0, `sys_rst_o` becomes 1 after exactly the third rising edge that samples the low level.
- R4: A single-cycle high pulse on `wdog_expire_i` asserts `sys_rst_o` on the third rising edge after it is sampled.
- R5: `mr_raw_n` low for at least MR_MIN_CYC = MR_TICKS*TICK_CYC consecutive sampled cycles asserts reset. A shorter low pulse, or a chain of shorter pulses broken by a high cycle, leaves `sys_rst_o` at 0 and raises no strobe.
- R6: `mr_seen_o` is high for exactly one cycle per accepted manual request, however long the line stays low. This holds even when another fault is already holding reset.
- R7: Once every input is healthy again (`supply_ok_i`=1, `monitor_ok_i`=1, `mr_raw_n`=1, `wdog_expire_i`=0), `sys_rst_o` falls on the HOLD_CYC+2-th rising edge after the first edge that samples the healthy values.
- R8: A fault that reappears while the hold count is running keeps `sys_rst_o` at 1. The count restarts, so release comes HOLD_CYC+2 edges after the last clean-up.
- R9: `sys_rst_n_o` is always the inverse of `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok_i | input | 1 | Supply-good comparator flag, asynchronous, 1 = healthy |
| monitor_ok_i | input | 1 | Auxiliary monitor-good flag, asynchronous, 1 = healthy |
| mr_raw_n | input | 1 | Raw manual reset request, asynchronous, active low |
| wdog_expire_i | input | 1 | Watchdog expiry pulse, 1 = timed out |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| mr_seen_o | output | 1 | One-cycle strobe on each accepted manual request |

## Verification
The bench sweeps the manual low-pulse width from one cycle up to two cycles past the minimum, and also sends a chain of sub-minimum pulses. An off-by-one qualifier would accept the width just below the limit or reject the width at the limit, and a qualifier that fails to clear would add the chained pulses together. Hold restart is checked by re-injecting a fault at every cycle of a running hold count. A timer that kept counting would release early. The exact assertion latency and release count are checked for each source, and this exposes a missing or extra synchroniser stage. The strobe count under long presses and under concurrent faults exposes a level-type strobe or one gated by the reset state.

// File: rtl/rst_sup_pkg.sv
// Shared types for the supervisory reset sequencer.
// Assumes every member is an active-high "condition present" flag.
package rst_sup_pkg;

    typedef struct packed {
        logic supply_bad;
        logic monitor_bad;
        logic manual_req;
        logic wdog_trip;
    } fault_vec_t;

    // True when any reset-requesting condition is present.
    function automatic logic any_fault(fault_vec_t f);
        return f.supply_bad | f.monitor_bad | f.manual_req | f.wdog_trip;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
// Multi-bit flop-chain synchroniser, one independent chain per bit.
// Assumes each bit is an unrelated level; no bus coherency is implied.
// The reset value is chosen per bit by RST_VAL so that idle levels are safe.
module rsup_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsup_debounce.sv
// Manual-request qualifier: accepts a synchronised low level only after
// MIN_CYC consecutive low cycles; any high cycle starts the count over.
// Produces a level while the request is valid and a one-cycle strobe on
// its start. Assumes low_i is already synchronous to clk.
module rsup_debounce #(
    parameter int MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    output logic active_o,
    output logic seen_o
);

    localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] run_q;
    logic          active_q;

    // Count earlier consecutive low cycles, saturating at MIN_CYC-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!low_i) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign active_o = low_i && (run_q == LAST);

    // Remember the previous valid state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_o;
    end

    assign seen_o = active_o && !active_q;

endmodule

// File: rtl/rsup_hold_timer.sv
// Shared release timer: holds reset while any fault is present and for
// HOLD_CYC clean cycles afterwards; a new fault restarts the count.
// Assumes fault_i is synchronous to clk. HOLD_CYC must be at least 2.
module rsup_hold_timer #(
    parameter int HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    output logic hold_rst_o
);

    localparam int CW = $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          rst_q;

    // Assert on power-on or fault, release after the clean hold count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
            cnt_q <= '0;
        end else if (fault_i) begin
            rst_q <= 1'b1;
            cnt_q <= '0;
        end else if (rst_q) begin
            if (cnt_q == LAST) begin
                rst_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hold_rst_o = rst_q;

endmodule

// File: rtl/rst_supervisor.sv
// Supervisory reset sequencer top. Synchronises the supervision inputs,
// qualifies the manual request, merges all fault sources and drives the
// complementary reset outputs from one shared hold timer.
// Assumes wdog_expire_i pulses last at least one clock cycle.
module rst_supervisor #(
    parameter int TICK_CYC   = 4,
    parameter int HOLD_TICKS = 5,
    parameter int MR_TICKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic monitor_ok_i,
    input  logic mr_raw_n,
    input  logic wdog_expire_i,
    output logic sys_rst_o,
    output logic sys_rst_n_o,
    output logic mr_seen_o
);
    import rst_sup_pkg::*;

    localparam int HOLD_CYC   = HOLD_TICKS * TICK_CYC;
    localparam int MR_MIN_CYC = MR_TICKS * TICK_CYC;
    localparam int NIN        = 4;
    // Idle-safe sync reset values: health flags low, manual line high.
    localparam logic [NIN-1:0] SYNC_RST = 4'b0010;

    logic [NIN-1:0] sync_q;
    logic           mr_active;
    logic           hold_rst;
    fault_vec_t     faults;

    rsup_sync #(
        .WIDTH   (NIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({supply_ok_i, monitor_ok_i, mr_raw_n, wdog_expire_i}),
        .q_o   (sync_q)
    );

    rsup_debounce #(
        .MIN_CYC (MR_MIN_CYC)
    ) u_mr (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_i    (!sync_q[1]),
        .active_o (mr_active),
        .seen_o   (mr_seen_o)
    );

    // Gather the synchronised fault conditions.
    always_comb begin
        faults.supply_bad  = !sync_q[3];
        faults.monitor_bad = !sync_q[2];
        faults.manual_req  = mr_active;
        faults.wdog_trip   = sync_q[0];
    end

    rsup_hold_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (any_fault(faults)),
        .hold_rst_o (hold_rst)
    );

    assign sys_rst_o   = hold_rst;
    assign sys_rst_n_o = !hold_rst;

endmodule

// File: rtl/rst_supervisor_chk.sv
// Property checker for the reset sequencer, bound to every instance.
// Assumes the default two-stage synchroniser (three-edge detection).
module rst_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic monitor_ok_i,
    input logic mr_raw_n,
    input logic wdog_expire_i,
    input logic sys_rst_o,
    input logic mr_seen_o
);

    assert_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> sys_rst_o);

    assert_supply_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok_i, 3) |-> sys_rst_o);

    assert_monitor_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(monitor_ok_i, 3) |-> sys_rst_o);

    assert_wdog_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wdog_expire_i, 3) |-> sys_rst_o);

    assert_seen_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mr_seen_o |=> sys_rst_o);

    assert_seen_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mr_seen_o |=> !mr_seen_o);

    assert_release_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> ($past(supply_ok_i, 3) && $past(monitor_ok_i, 3)
                              && $past(mr_raw_n, 3) && !$past(wdog_expire_i, 3)));

endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok_i),
    .monitor_ok_i  (monitor_ok_i),
    .mr_raw_n      (mr_raw_n),
    .wdog_expire_i (wdog_expire_i),
    .sys_rst_o     (sys_rst_o),
    .mr_seen_o     (mr_seen_o)
);

// File: tb/rst_supervisor_test.sv
// Self-checking bench: sweeps pulse widths, fault sources and hold restarts.
module rst_supervisor_test;

    localparam int TICK  = 4;
    localparam int HT    = 5;
    localparam int MT    = 2;
    localparam int HOLD  = HT * TICK;
    localparam int MRMIN = MT * TICK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic monitor_ok = 1'b1;
    logic mr_n = 1'b1;
    logic wdog = 1'b0;
    logic sys_rst, sys_rst_n, mr_seen;

    int checks = 0;
    int failures = 0;
    int seen_cnt = 0;
    int comp_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rst_supervisor #(.TICK_CYC(TICK), .HOLD_TICKS(HT), .MR_TICKS(MT)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .monitor_ok_i(monitor_ok),
        .mr_raw_n(mr_n), .wdog_expire_i(wdog), .sys_rst_o(sys_rst),
        .sys_rst_n_o(sys_rst_n), .mr_seen_o(mr_seen)
    );

    // Count strobes and complement mismatches away from the active edge.
    always @(negedge clk) begin
        if (mr_seen === 1'b1) seen_cnt++;
        if (sys_rst_n !== ~sys_rst) comp_err++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edges from now until reset is seen high then low; asserted reports if it ever rose.
    task automatic measure(output int n, output bit asserted);
        n = 0;
        asserted = sys_rst;
        while (n < HOLD + 12) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (sys_rst) asserted = 1'b1;
            else if (asserted) break;
        end
    endtask

    // Edges until reset rises, called right after a fault input is applied.
    task automatic latency(output int n);
        n = 0;
        while (n < 10) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (sys_rst) break;
        end
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        int n;
        bit a;
        cycles(3);
        check(sys_rst == 1'b1, "R1 reset level", sys_rst, 1);
        check(sys_rst_n == 1'b0, "R9 reset complement", sys_rst_n, 0);
        rst_n = 1'b1;
        measure(n, a);
        check(n == HOLD + 2, "R1 power-up release edges", n, HOLD + 2);
        cycles(2);

        // R2: supply faults of several lengths
        for (int d = 0; d < 4; d++) begin
            supply_ok = 1'b0;
            latency(n);
            check(n == 3, "R2 supply detect latency", n, 3);
            cycles(d);
            supply_ok = 1'b1;
            measure(n, a);
            check(n == HOLD + 2, "R7 release after supply", n, HOLD + 2);
            cycles(2);
        end

        // R3: monitor faults
        for (int d = 0; d < 3; d++) begin
            monitor_ok = 1'b0;
            latency(n);
            check(n == 3, "R3 monitor detect latency", n, 3);
            cycles(d);
            monitor_ok = 1'b1;
            measure(n, a);
            check(n == HOLD + 2, "R7 release after monitor", n, HOLD + 2);
            cycles(2);
        end

        // R3: one-cycle monitor dip still caught
        monitor_ok = 1'b0;
        cycles(1);
        monitor_ok = 1'b1;
        measure(n, a);
        check(a && n == HOLD + 2, "R3 short monitor dip", n, HOLD + 2);
        cycles(2);

        // R4: single-cycle watchdog pulse
        wdog = 1'b1;
        cycles(1);
        wdog = 1'b0;
        measure(n, a);
        check(a == 1'b1, "R4 watchdog asserts", a, 1);
        check(n == HOLD + 2, "R7 release after watchdog", n, HOLD + 2);
        cycles(2);

        // R5/R6: manual pulse width sweep around the minimum
        for (int w = 1; w <= MRMIN + 2; w++) begin
            seen_cnt = 0;
            mr_n = 1'b0;
            cycles(w);
            mr_n = 1'b1;
            measure(n, a);
            if (w >= MRMIN) begin
                check(a == 1'b1, "R5 valid manual press asserts", a, 1);
                check(n == HOLD + 2, "R7 release after manual", n, HOLD + 2);
                check(seen_cnt == 1, "R6 one strobe per press", seen_cnt, 1);
            end else begin
                check(a == 1'b0, "R5 short manual press ignored", a, 0);
                check(seen_cnt == 0, "R5 no strobe on short press", seen_cnt, 0);
            end
            cycles(2);
        end

        // R5: chained sub-minimum pulses do not accumulate
        seen_cnt = 0;
        for (int p = 0; p < 3; p++) begin
            mr_n = 1'b0;
            cycles(MRMIN - 1);
            mr_n = 1'b1;
            cycles(1);
        end
        measure(n, a);
        check(a == 1'b0, "R5 chained short presses ignored", a, 0);
        check(seen_cnt == 0, "R5 no strobe on chained presses", seen_cnt, 0);

        // R6: strobe still raised while another fault holds reset
        supply_ok = 1'b0;
        cycles(4);
        seen_cnt = 0;
        mr_n = 1'b0;
        cycles(MRMIN + 5);
        mr_n = 1'b1;
        supply_ok = 1'b1;
        measure(n, a);
        check(seen_cnt == 1, "R6 strobe during supply fault", seen_cnt, 1);
        check(n == HOLD + 2, "R7 release after combined faults", n, HOLD + 2);
        cycles(2);

        // R8: re-inject a fault at every point of a running hold count
        for (int j = 1; j < HOLD; j++) begin
            bit dropped = 1'b0;
            supply_ok = 1'b0;
            cycles(3);
            supply_ok = 1'b1;
            for (int k = 0; k < j; k++) begin
                @(negedge clk);
                if (!sys_rst) dropped = 1'b1;
            end
            supply_ok = 1'b0;
            cycles(1);
            supply_ok = 1'b1;
            measure(n, a);
            check(!dropped, "R8 reset held during restart", dropped, 0);
            check(n == HOLD + 2, "R8 restarted hold length", n, HOLD + 2);
            cycles(2);
        end

        // R7: staggered clean-up, release counted from the last one
        supply_ok = 1'b0;
        monitor_ok = 1'b0;
        cycles(4);
        supply_ok = 1'b1;
        cycles(5);
        monitor_ok = 1'b1;
        measure(n, a);
        check(n == HOLD + 2, "R7 release after last source", n, HOLD + 2);

        check(comp_err == 0, "R9 outputs complementary", comp_err, 0);
        check(sys_rst == 1'b0, "R7 idle after release", sys_rst, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule